// File: doc/BRIEF.md
# I2C Slave Address-Match Front End

This block is the bus-facing front end of an I2C/SMBus slave peripheral, for example a small GPIO expander. It samples the SCL and SDA lines with the system clock and recognises START and STOP conditions. It shifts in the first byte after a START and compares its upper seven bits with the slave address. That address is a fixed four-bit prefix followed by three pins strapped on the board, so up to eight identical devices can share one bus.

On a match the block pulls SDA low for the acknowledge bit and latches the requested transfer direction. In a write transfer it collects each following data byte and presents it to downstream logic with a one-cycle strobe. It also acknowledges each of those bytes. In a read transfer it stays off the bus and leaves the data path to downstream logic. A STOP ends the transaction with a one-cycle pulse. A repeated START restarts address reception.

The system clock must run at least 8 times faster than SCL. Both bus lines pass through a two-flop synchronizer before any detection.

Top module: `i2c_addr_front`

## Requirements
- R1: After reset, and until a START is seen, the block drives nothing, reports no match, gives no strobe and gives no end pulse, even when SCL is clocked with a matching address on SDA.
- R2: A START condition (SDA falling while SCL is high) begins address reception from any state.
- R3: A STOP condition (SDA rising while SCL is high) returns the block to idle and clears `addr_hit`. If a START has been seen since the last idle, it also raises `xfer_end` for exactly one clock. This applies even in the middle of a byte.
- R4: The first byte after START is taken MSB first on SCL rising edges. It matches when byte bits 7..4 equal 0100 and byte bits 3..1 equal `sel_pins[2:0]`, with `sel_pins[2]` at byte bit 3.
- R5: On a match, `rd_mode` takes byte bit 0: a 1 selects a read and a 0 selects a write. It keeps that value until the next match.
- R6: On a match, `sda_drive` rises only while SCL is low, before the ninth SCL rising edge. It stays high through the ninth SCL high period and falls after the ninth SCL falling edge.
- R7: On a mismatch, the block gives no acknowledge and keeps `sda_drive` low until the next START. `addr_hit` stays low.
- R8: In a matched write, every 8 further bits produce one single-cycle `byte_strobe` with `byte_data` holding those bits MSB first. Each such byte is acknowledged as in R6.
- R9: A repeated START after a partial data byte restarts address reception and produces no strobe for the partial byte.
- R10: In a matched read, after the address acknowledge, the block never drives SDA and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | SCL line as seen on the pad |
| sda_in | input | 1 | SDA line as seen on the pad (wired-AND of all drivers) |
| sel_pins | input | 3 | Strapped low three address bits |
| sda_drive | output | 1 | 1 = pull SDA low (open-drain enable) |
| addr_hit | output | 1 | Address matched in the current transaction |
| rd_mode | output | 1 | Latched direction bit, 1 = read |
| byte_strobe | output | 1 | One-cycle pulse: a write data byte is complete |
| byte_data | output | 8 | Last write data byte received |
| xfer_end | output | 1 | One-cycle pulse on a STOP that ends a transaction |

## Verification
Each bus edge reaches the detection logic two clocks after it is driven. The registered result appears on the third rising clock edge. The bench spaces every SCL and SDA change 5 clocks apart and samples outputs just before the next bus change, so each level check falls after its result is due and before it can move again. The strobe and end pulses last one clock, so the bench counts them on every falling clock edge and compares the totals after each bus phase. The acknowledge is checked on the wired SDA line in the middle of the ninth SCL high period.

// File: rtl/i2c_addr_front.sv
module i2c_addr_front #(
  parameter logic [3:0] PREFIX = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] sel_pins,
  output logic       sda_drive,
  output logic       addr_hit,
  output logic       rd_mode,
  output logic       byte_strobe,
  output logic [7:0] byte_data,
  output logic       xfer_end
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_DATA, S_SKIP} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl, scl_q, sda, sda_q;
  logic       start_c, stop_c, rise, fall, match;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign scl     = scl_p[1];
  assign scl_q   = scl_p[2];
  assign sda     = sda_p[1];
  assign sda_q   = sda_p[2];
  assign start_c = scl & scl_q & sda_q & ~sda;
  assign stop_c  = scl & scl_q & ~sda_q & sda;
  assign rise    = scl & ~scl_q;
  assign fall    = ~scl & scl_q;
  assign match   = (sr[7:1] == {PREFIX, sel_pins});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sr          <= '0;
      sda_drive   <= 1'b0;
      addr_hit    <= 1'b0;
      rd_mode     <= 1'b0;
      byte_strobe <= 1'b0;
      byte_data   <= '0;
      xfer_end    <= 1'b0;
    end else begin
      byte_strobe <= 1'b0;
      xfer_end    <= 1'b0;
      if (start_c) begin
        st        <= S_ADDR;
        cnt       <= '0;
        addr_hit  <= 1'b0;
        sda_drive <= 1'b0;
      end else if (stop_c) begin
        if (st != S_IDLE) xfer_end <= 1'b1;
        st        <= S_IDLE;
        addr_hit  <= 1'b0;
        sda_drive <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (st == S_ADDR || !rd_mode) begin
              if (rise && cnt != 4'd8) begin
                sr  <= {sr[6:0], sda};
                cnt <= cnt + 4'd1;
              end else if (fall && cnt == 4'd8) begin
                cnt <= '0;
                if (st == S_DATA) begin
                  byte_strobe <= 1'b1;
                  byte_data   <= sr;
                  sda_drive   <= 1'b1;
                  st          <= S_ACK;
                end else if (match) begin
                  addr_hit  <= 1'b1;
                  rd_mode   <= sr[0];
                  sda_drive <= 1'b1;
                  st        <= S_ACK;
                end else begin
                  st <= S_SKIP;
                end
              end
            end
          end
          S_ACK: begin
            if (fall) begin
              sda_drive <= 1'b0;
              st        <= S_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  ack_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive) |-> !$past(scl));

  // R7
  drive_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive |-> addr_hit);

  // R3
  end_clears_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> !addr_hit);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |=> !byte_strobe);

  // R10
  read_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && rd_mode) |-> !sda_drive);

endmodule

// File: tb/sim_i2c_addr_front.sv
module sim_i2c_addr_front;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       sda_line;
  logic       sda_drive, addr_hit, rd_mode, byte_strobe, xfer_end;
  logic [7:0] byte_data;

  assign sda_line = sda_m & ~sda_drive;

  i2c_addr_front u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sel_pins(sel), .sda_drive(sda_drive), .addr_hit(addr_hit),
    .rd_mode(rd_mode), .byte_strobe(byte_strobe), .byte_data(byte_data),
    .xfer_end(xfer_end)
  );

  int nchk = 0, nfail = 0;
  int stb_cnt = 0, end_cnt = 0;
  logic [7:0] last_byte = '0;
  logic drive_seen = 1'b0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (byte_strobe) begin
      stb_cnt   <= stb_cnt + 1;
      last_byte <= byte_data;
    end
    if (xfer_end) end_cnt <= end_cnt + 1;
    if (sda_drive) drive_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    seen = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_line);
    logic dummy;
    for (int i = 7; i >= 0; i--) send_bit(v[i], dummy);
    send_bit(1'b1, ack_line);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
    wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic dummy;
    int s0, e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!sda_drive && !addr_hit && !byte_strobe && !xfer_end, "R1 reset",
        {sda_drive, addr_hit, byte_strobe, xfer_end}, 0);

    // R1 clocking before any START gets no response
    sel = 3'd2;
    scl_m = 1'b0; wq();
    send_byte({4'b0100, 3'd2, 1'b0}, ack);
    chk(ack == 1'b1, "R1 no ack before START", ack, 1);
    chk(!addr_hit, "R1 no hit before START", addr_hit, 0);
    send_byte(8'hA5, ack);
    bus_stop();
    chk(stb_cnt == 0, "R1 no strobe before START", stb_cnt, 0);
    chk(end_cnt == 0, "R1 no end pulse from idle", end_cnt, 0);

    // R3 STOP in the middle of the address byte
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(i[0], dummy);
    bus_stop();
    chk(end_cnt == 1, "R3 end pulse on mid-byte STOP", end_cnt, 1);
    chk(!addr_hit, "R3 idle after STOP", addr_hit, 0);

    // Sweep: R2 R4 R5 R6 R7 R8 R10
    for (int s = 0; s < 8; s++) begin
      sel = s[2:0];
      for (int k = 0; k < 31; k++) begin
        int p, lo, rw;
        bit hit;
        logic [7:0] d;
        if (k < 16) begin p = 4; lo = k >> 1; rw = k & 1; end
        else begin p = (k - 16 < 4) ? k - 16 : k - 15; lo = s; rw = 0; end
        hit = (p == 4) && (lo == s);
        d = 8'((s * 29 + lo * 7 + p * 13 + k) & 255);
        s0 = stb_cnt; e0 = end_cnt;
        bus_start();
        send_byte({p[3:0], lo[2:0], rw[0]}, ack);
        chk(ack == !hit, "R4 R6 address acknowledge", ack, !hit);
        chk(addr_hit == hit, "R4 addr_hit", addr_hit, hit);
        chk(!sda_drive, "R6 released after ninth fall", sda_drive, 0);
        if (hit) chk(rd_mode == rw[0], "R5 direction latch", rd_mode, rw);
        drive_seen = 1'b0;
        send_byte(d, ack);
        if (hit && rw == 0) begin
          chk(ack == 1'b0, "R8 data acknowledge", ack, 0);
          chk(stb_cnt == s0 + 1, "R8 one strobe per byte", stb_cnt, s0 + 1);
          chk(last_byte == d, "R8 byte_data", last_byte, d);
        end else if (hit) begin
          chk(!drive_seen, "R10 read phase passive", drive_seen, 0);
          chk(stb_cnt == s0, "R10 no strobe in read", stb_cnt, s0);
        end else begin
          chk(!drive_seen, "R7 no drive after mismatch", drive_seen, 0);
          chk(stb_cnt == s0, "R7 no strobe after mismatch", stb_cnt, s0);
        end
        bus_stop();
        chk(end_cnt == e0 + 1, "R3 end pulse", end_cnt, e0 + 1);
        chk(!addr_hit, "R3 hit cleared by STOP", addr_hit, 0);
      end
    end

    // R9 repeated START after a partial data byte
    sel = 3'd3;
    s0 = stb_cnt; e0 = end_cnt;
    bus_start();
    send_byte({4'b0100, 3'd3, 1'b0}, ack);
    chk(ack == 1'b0, "R9 first address ack", ack, 0);
    for (int i = 0; i < 3; i++) send_bit(1'b0, dummy);
    bus_start();
    chk(!addr_hit, "R9 repeated START clears hit", addr_hit, 0);
    send_byte({4'b0100, 3'd3, 1'b1}, ack);
    chk(ack == 1'b0, "R9 second address ack", ack, 0);
    chk(rd_mode == 1'b1, "R9 read after repeated START", rd_mode, 1);
    chk(stb_cnt == s0, "R9 no strobe for partial byte", stb_cnt, s0);
    chk(end_cnt == e0, "R9 no end pulse without STOP", end_cnt, e0);
    bus_stop();
    chk(end_cnt == e0 + 1, "R3 end after repeated START", end_cnt, e0 + 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule